// File: doc/BRIEF.md
# Multi-Mode Operand Addressing Accumulate Unit

This unit carries out one two-operand accumulate per command: `R[dst] <- R[dst] + operand`. The mode code picks where the operand comes from. It can be a constant carried in the command or a second register. It can also be a memory word whose address is built from the constant, a base register, an index register and an element size. The unit holds an eight-entry, 32-bit register file. It drives one word-wide memory read port whose response may arrive after any number of cycles.

A command is taken only while `op_ready` is high. The mode code decides how many memory reads the command needs: zero, one or two. For the two auto modes the unit also writes the stepped base register back. When the destination has been written, a one-cycle `done` pulse appears together with the written value on `result`. A register can be read back by issuing an immediate add of zero to it. A mode code outside the defined set raises `bad_mode` for one cycle and changes nothing.

Top module: `addr_accum_unit`

## Requirements
- R1: After reset every register reads zero, `done`, `bad_mode` and `mem_req` are low, and `op_ready` is high.
- R2: Mode 0 (constant) adds the zero-extended `op_const` to `R[dst]` and makes no memory request.
- R3: Mode 1 (register) adds `R[src]` to `R[dst]` and makes no memory request.
- R4: Mode 2 (absolute) makes one read at the zero-extended `op_const`, so only the low 2^16 addresses can be reached. The word returned is added to `R[dst]`.
- R5: One read is made, and the word returned is added, at these addresses: `R[src]` in mode 3 (base), `R[src] + R[idx]` in mode 4 (base plus index), and `op_const + R[src]` in mode 5 (base plus offset).
- R6: Mode 6 (double dereference) first reads at `R[src]`. It then reads at the word that came back, and adds the second word.
- R7: Mode 7 (post-step) reads at the old `R[src]` and afterwards sets `R[src]` to `R[src] + d`. Here d = 1 << `op_dsize`, so codes 0..3 give 1, 2, 4 and 8.
- R8: Mode 8 (pre-step) sets `R[src]` to `R[src] - d` and reads at that lowered value.
- R9: Mode 9 (scaled) reads at `op_const + R[src] + R[idx] * d`.
- R10: When `dst` equals `src` in modes 7 and 8, the register ends up holding the old `R[dst]` plus the operand. The stepped base value is lost.
- R11: Mode codes 10 to 15 give a one-cycle `bad_mode` pulse, one cycle after the accepting edge. They produce no `done`, no memory request and no register change.
- R12: `op_ready` is high only while idle, and `op_valid` is ignored while it is low. `mem_req` stays high with a stable `mem_addr` until `mem_rvalid`. `done` is a single-cycle pulse.
- R13: Take L as the number of extra cycles the memory waits before `mem_rvalid` on each read. Counted from the accepting edge, `done` rises after 1 edge in modes 0 and 1, after 3 + L edges for single-read modes, and after 5 + 2L edges in mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command present |
| op_ready | output | 1 | Unit idle, command is taken on this edge |
| op_mode | input | 4 | Mode code 0..9, other codes illegal |
| op_dst | input | 3 | Destination register index |
| op_src | input | 3 | Base or second source register index |
| op_idx | input | 3 | Index register index |
| op_const | input | 16 | Constant, absolute address or offset |
| op_dsize | input | 2 | Element size code, d = 1 << code |
| mem_req | output | 1 | Read request, held until served |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Destination written (one-cycle pulse) |
| result | output | 32 | Value written to the destination |
| bad_mode | output | 1 | Illegal mode code seen (one-cycle pulse) |

## Verification
The bench drives each command just before a rising edge. From that edge it counts edges on falling-edge samples until `done`. The count is compared with 1, 3 + L or 5 + 2L edges, where the bench's memory model sets L per command. An illegal code is checked on the very next falling edge, where `bad_mode` must be high and `done` and `mem_req` low. The flag is checked again one cycle later, when it must have dropped. Register contents, including stepped bases, are read back with constant-mode adds of zero. This read-back happens only after `done`, so every expected value refers to a completed command.

// File: rtl/addr_accum_pkg.sv
// Shared definitions for the addressing accumulate unit: the mode code
// enumeration and the legality test applied to an incoming mode code.
package addr_accum_pkg;

    localparam int MODE_W     = 4;
    localparam int MODE_COUNT = 10;

    typedef enum logic [MODE_W-1:0] {
        MD_IMM   = 4'd0,
        MD_REG   = 4'd1,
        MD_ABS   = 4'd2,
        MD_BASE  = 4'd3,
        MD_BIDX  = 4'd4,
        MD_BOFS  = 4'd5,
        MD_DDREF = 4'd6,
        MD_POST  = 4'd7,
        MD_PRE   = 4'd8,
        MD_SCALE = 4'd9
    } mode_e;

    // True when the code names one of the defined modes.
    function automatic logic mode_is_legal(input logic [MODE_W-1:0] code);
        return (32'(code) < MODE_COUNT);
    endfunction

endpackage

// File: rtl/addr_accum_regfile.sv
// Register file for the accumulate unit.
// Three asynchronous read ports and two write ports. The main (destination)
// write port takes priority over the base-update port when both address the
// same entry. Assumes both writes come from the same controller cycle.
module addr_accum_regfile #(
    parameter int NREG = 8,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    input  logic [AW-1:0]   ra_c,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_c,
    input  logic            we_main,
    input  logic [AW-1:0]   wa_main,
    input  logic [XLEN-1:0] wd_main,
    input  logic            we_base,
    input  logic [AW-1:0]   wa_base,
    input  logic [XLEN-1:0] wd_base
);

    logic [XLEN-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
        // One entry: clear on reset, main write wins over base write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (we_main && (wa_main == AW'(gi))) begin
                regs[gi] <= wd_main;
            end else if (we_base && (wa_base == AW'(gi))) begin
                regs[gi] <= wd_base;
            end
        end
    end

    // Asynchronous reads.
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];

    AST_MAIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_main && we_base && (wa_main == wa_base)) |=> (regs[$past(wa_main)] == $past(wd_main))); // R10

endmodule

// File: rtl/addr_accum_agen.sv
// Address generator for the accumulate unit.
// Purely combinational. From the latched mode, the base and index register
// values, the constant and the element-size code it forms the effective
// address, the stepped base value, and the flags saying whether memory is
// read, whether two reads chain, and whether the base is written back.
// Assumes the constant is narrower than the data word (zero-extended).
module addr_accum_agen
    import addr_accum_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CONST_W = 16,
    parameter int DSEL_W  = 2
) (
    input  mode_e               mode,
    input  logic [XLEN-1:0]     base_val,
    input  logic [XLEN-1:0]     index_val,
    input  logic [CONST_W-1:0]  konst,
    input  logic [DSEL_W-1:0]   dsel,
    output logic [XLEN-1:0]     eff_addr,
    output logic [XLEN-1:0]     base_next,
    output logic                uses_mem,
    output logic                two_reads,
    output logic                auto_upd
);

    logic [XLEN-1:0] step;
    logic [XLEN-1:0] kx;
    logic [XLEN-1:0] scaled;

    // Element size and scaled index are shifts, never multiplies.
    always_comb begin
        step   = XLEN'(1) << dsel;
        kx     = XLEN'(konst);
        scaled = index_val << dsel;
    end

    // Per-mode address and side effects.
    always_comb begin
        eff_addr  = '0;
        base_next = base_val;
        uses_mem  = 1'b1;
        two_reads = 1'b0;
        auto_upd  = 1'b0;
        case (mode)
            MD_IMM, MD_REG: uses_mem = 1'b0;
            MD_ABS:   eff_addr = kx;
            MD_BASE:  eff_addr = base_val;
            MD_BIDX:  eff_addr = base_val + index_val;
            MD_BOFS:  eff_addr = kx + base_val;
            MD_DDREF: begin
                eff_addr  = base_val;
                two_reads = 1'b1;
            end
            MD_POST: begin
                eff_addr  = base_val;
                base_next = base_val + step;
                auto_upd  = 1'b1;
            end
            MD_PRE: begin
                base_next = base_val - step;
                eff_addr  = base_val - step;
                auto_upd  = 1'b1;
            end
            MD_SCALE: eff_addr = kx + base_val + scaled;
            default:  uses_mem = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_accum_ctrl.sv
// Sequencer for the accumulate unit.
// Takes a command while idle and latches its fields. It spends one cycle
// evaluating, then issues zero, one or two memory reads and finishes by
// asking for the destination write (and base write for the auto modes).
// Assumes the memory answers each held request with one mem_rvalid cycle.
module addr_accum_ctrl
    import addr_accum_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CONST_W = 16,
    parameter int AW      = 3,
    parameter int DSEL_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [MODE_W-1:0]   op_mode,
    input  logic [AW-1:0]       op_dst,
    input  logic [AW-1:0]       op_src,
    input  logic [AW-1:0]       op_idx,
    input  logic [CONST_W-1:0]  op_const,
    input  logic [DSEL_W-1:0]   op_dsize,
    output logic                op_ready,
    output mode_e               mode_q,
    output logic [AW-1:0]       dst_q,
    output logic [AW-1:0]       src_q,
    output logic [AW-1:0]       idx_q,
    output logic [CONST_W-1:0]  k_q,
    output logic [DSEL_W-1:0]   dsel_q,
    input  logic [XLEN-1:0]     dst_val,
    input  logic [XLEN-1:0]     src_val,
    input  logic [XLEN-1:0]     eff_addr,
    input  logic                uses_mem,
    input  logic                two_reads,
    input  logic                auto_upd,
    output logic                mem_req,
    output logic [XLEN-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                we_main,
    output logic [XLEN-1:0]     wd_main,
    output logic                we_base,
    output logic                done,
    output logic [XLEN-1:0]     result,
    output logic                bad_mode
);

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RD1, ST_RD2} state_e;

    state_e          state_q;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] sum;
    logic            finish;

    // Pick the operand and decide whether this cycle completes the command.
    always_comb begin
        if (state_q == ST_EXEC) begin
            operand = (mode_q == MD_REG) ? src_val : XLEN'(k_q);
        end else begin
            operand = mem_rdata;
        end
        finish = ((state_q == ST_EXEC) && !uses_mem)
              || ((state_q == ST_RD1) && mem_rvalid && !two_reads)
              || ((state_q == ST_RD2) && mem_rvalid);
        sum = dst_val + operand;
    end

    assign op_ready = (state_q == ST_IDLE);
    assign mem_req  = (state_q == ST_RD1) || (state_q == ST_RD2);
    assign we_main  = finish;
    assign wd_main  = sum;
    assign we_base  = finish && auto_upd;

    // Command latch, state sequencing and memory address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MD_IMM;
            dst_q    <= '0;
            src_q    <= '0;
            idx_q    <= '0;
            k_q      <= '0;
            dsel_q   <= '0;
            mem_addr <= '0;
            bad_mode <= 1'b0;
        end else begin
            bad_mode <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        if (mode_is_legal(op_mode)) begin
                            mode_q  <= mode_e'(op_mode);
                            dst_q   <= op_dst;
                            src_q   <= op_src;
                            idx_q   <= op_idx;
                            k_q     <= op_const;
                            dsel_q  <= op_dsize;
                            state_q <= ST_EXEC;
                        end else begin
                            bad_mode <= 1'b1;
                        end
                    end
                end
                ST_EXEC: begin
                    if (uses_mem) begin
                        mem_addr <= eff_addr;
                        state_q  <= ST_RD1;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_RD1: begin
                    if (mem_rvalid) begin
                        if (two_reads) begin
                            mem_addr <= mem_rdata;
                            state_q  <= ST_RD2;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_RD2: begin
                    if (mem_rvalid) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse and captured written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= sum;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> op_ready); // R12
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R12
    AST_NOMEM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXEC) && !uses_mem) |=> (done && !mem_req)); // R13
    AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (op_ready && !done && !mem_req)); // R11

endmodule

// File: rtl/addr_accum_unit.sv
// Top of the multi-mode addressing accumulate unit.
// Connects the sequencer, the address generator and the register file.
// The destination port of the register file reads the latched destination,
// the second port the base/source, the third the index register.
// Assumes a single memory read port with request/valid handshake.
module addr_accum_unit
    import addr_accum_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int XLEN    = 32,
    parameter int CONST_W = 16,
    parameter int DSEL_W  = 2,
    localparam int AW     = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic [MODE_W-1:0]   op_mode,
    input  logic [AW-1:0]       op_dst,
    input  logic [AW-1:0]       op_src,
    input  logic [AW-1:0]       op_idx,
    input  logic [CONST_W-1:0]  op_const,
    input  logic [DSEL_W-1:0]   op_dsize,
    output logic                mem_req,
    output logic [XLEN-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                done,
    output logic [XLEN-1:0]     result,
    output logic                bad_mode
);

    mode_e               mode_q;
    logic [AW-1:0]       dst_q, src_q, idx_q;
    logic [CONST_W-1:0]  k_q;
    logic [DSEL_W-1:0]   dsel_q;
    logic [XLEN-1:0]     dst_val, src_val, idx_val;
    logic [XLEN-1:0]     eff_addr, base_next, wd_main;
    logic                uses_mem, two_reads, auto_upd, we_main, we_base;

    addr_accum_ctrl #(
        .XLEN(XLEN), .CONST_W(CONST_W), .AW(AW), .DSEL_W(DSEL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_mode(op_mode), .op_dst(op_dst),
        .op_src(op_src), .op_idx(op_idx), .op_const(op_const),
        .op_dsize(op_dsize), .op_ready(op_ready),
        .mode_q(mode_q), .dst_q(dst_q), .src_q(src_q), .idx_q(idx_q),
        .k_q(k_q), .dsel_q(dsel_q),
        .dst_val(dst_val), .src_val(src_val),
        .eff_addr(eff_addr), .uses_mem(uses_mem), .two_reads(two_reads),
        .auto_upd(auto_upd),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .we_main(we_main), .wd_main(wd_main), .we_base(we_base),
        .done(done), .result(result), .bad_mode(bad_mode)
    );

    addr_accum_agen #(
        .XLEN(XLEN), .CONST_W(CONST_W), .DSEL_W(DSEL_W)
    ) u_agen (
        .mode(mode_q), .base_val(src_val), .index_val(idx_val),
        .konst(k_q), .dsel(dsel_q),
        .eff_addr(eff_addr), .base_next(base_next),
        .uses_mem(uses_mem), .two_reads(two_reads), .auto_upd(auto_upd)
    );

    addr_accum_regfile #(
        .NREG(NREG), .XLEN(XLEN)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(dst_q), .ra_b(src_q), .ra_c(idx_q),
        .rd_a(dst_val), .rd_b(src_val), .rd_c(idx_val),
        .we_main(we_main), .wa_main(dst_q), .wd_main(wd_main),
        .we_base(we_base), .wa_base(src_q), .wd_base(base_next)
    );

endmodule

// File: tb/addr_accum_unit_bench.sv
`timescale 1ns/1ps
module addr_accum_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [3:0]  op_mode = '0;
    logic [2:0]  op_dst = '0, op_src = '0, op_idx = '0;
    logic [15:0] op_const = '0;
    logic [1:0]  op_dsize = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] result;
    logic        bad_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int mem_lat = 0;
    int wait_c  = 0;
    int nreads  = 0;
    logic [31:0] alog [2];
    logic [31:0] m [8];

    always #2.5 clk = ~clk;

    addr_accum_unit u_addr_accum_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_mode(op_mode), .op_dst(op_dst), .op_src(op_src), .op_idx(op_idx),
        .op_const(op_const), .op_dsize(op_dsize),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .result(result), .bad_mode(bad_mode)
    );

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        return a * 32'd5 + 32'h0000_1234;
    endfunction

    // Memory model: answers a held request after mem_lat extra cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            wait_c = 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && !mem_rvalid) begin
                if (wait_c >= mem_lat) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem_f(mem_addr);
                    if (nreads < 2) alog[nreads] = mem_addr;
                    nreads++;
                    wait_c = 0;
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command at the next edge and wait for done (edges counted).
    task automatic drive(input int mode, input int dst, input int src, input int idx,
                         input int k, input int ds, output logic [31:0] res, output int edges);
        op_mode = 4'(mode); op_dst = 3'(dst); op_src = 3'(src); op_idx = 3'(idx);
        op_const = 16'(k); op_dsize = 2'(ds); op_valid = 1'b1; nreads = 0;
        @(posedge clk); #1 op_valid = 1'b0;
        edges = -1; res = '0;
        for (int i = 1; i < 300; i++) begin
            @(negedge clk);
            if (done) begin res = result; edges = i - 1; break; end
        end
    endtask

    task automatic rd_reg(input int r, output logic [31:0] v);
        int e;
        drive(0, r, 0, 0, 0, 0, v, e);
    endtask

    function automatic string tag_of(input int mode);
        case (mode)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R5";
        endcase
    endfunction

    // Run one legal command against the bench's own register model.
    task automatic run_op(input int mode, input int dst, input int src, input int idx,
                          input int k, input int ds, input int lat);
        logic [31:0] d, a0, a1, opnd, nb, exp_sum, res, rb;
        int reads, lat_exp, edges;
        string t;
        t = tag_of(mode);
        d = 32'd1 << ds;
        a0 = '0; a1 = '0; opnd = '0; nb = m[src]; reads = 1;
        case (mode)
            0: begin opnd = 32'(k); reads = 0; end
            1: begin opnd = m[src]; reads = 0; end
            2: a0 = 32'(k);
            3: a0 = m[src];
            4: a0 = m[src] + m[idx];
            5: a0 = 32'(k) + m[src];
            6: begin a0 = m[src]; a1 = mem_f(a0); reads = 2; end
            7: begin a0 = m[src]; nb = m[src] + d; end
            8: begin a0 = m[src] - d; nb = a0; end
            default: a0 = 32'(k) + m[src] + (m[idx] << ds);
        endcase
        if (reads == 1) opnd = mem_f(a0);
        if (reads == 2) opnd = mem_f(a1);
        exp_sum = m[dst] + opnd;
        lat_exp = (reads == 0) ? 1 : (reads == 1) ? 3 + lat : 5 + 2 * lat;
        mem_lat = lat;
        drive(mode, dst, src, idx, k, ds, res, edges);
        if (mode == 7 || mode == 8) m[src] = nb;
        m[dst] = exp_sum;
        chk(res == exp_sum, (dst == src && (mode == 7 || mode == 8)) ? "R10" : t, res, exp_sum);
        chk(edges == lat_exp, "R13 latency", 32'(edges), 32'(lat_exp));
        chk(nreads == reads, {t, " read count"}, 32'(nreads), 32'(reads));
        if (reads >= 1) chk(alog[0] == a0, {t, " first address"}, alog[0], a0);
        if (reads == 2) chk(alog[1] == a1, "R6 second address", alog[1], a1);
        mem_lat = 0;
        rd_reg(src, rb);
        chk(rb == m[src], (mode == 7 || mode == 8) ? ((dst == src) ? "R10 base" : {t, " base"}) : {t, " src"}, rb, m[src]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, r1;
        int e;
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!done && !bad_mode && !mem_req, "R1 outputs", {29'd0, done, bad_mode, mem_req}, 32'd0);
        chk(op_ready, "R1 ready", 32'(op_ready), 32'd1);
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, v);
            chk(v == 32'd0, "R1 register", v, 32'd0);
        end
        // Seed registers with constant adds (R2).
        for (int i = 0; i < 8; i++) run_op(0, i, i, 0, 16'h0140 + i * 16'h0333, 0, 0);

        // Sweep of legal modes, element sizes and register overlaps.
        for (int md = 0; md < 10; md++) begin
            for (int ds = 0; ds < 4; ds++) begin
                for (int c = 0; c < 4; c++) begin
                    int dst, src, idx;
                    case (c)
                        0: begin dst = 1; src = 2; idx = 3; end
                        1: begin dst = 4; src = 4; idx = 5; end
                        2: begin dst = 6; src = 7; idx = 7; end
                        default: begin dst = 0; src = 3; idx = 2; end
                    endcase
                    run_op(md, dst, src, idx, 32 + 16 * md + 4 * ds + c, ds, (md + ds + c) % 3);
                end
            end
        end

        // R12: a command offered while busy is ignored.
        mem_lat = 4;
        op_mode = 4'd2; op_dst = 3'd1; op_src = 3'd0; op_idx = 3'd0;
        op_const = 16'h0050; op_dsize = 2'd0; op_valid = 1'b1; nreads = 0;
        @(posedge clk); #1;
        op_mode = 4'd0; op_dst = 3'd5; op_const = 16'd7;
        @(negedge clk);
        chk(!op_ready, "R12 busy ready low", 32'(op_ready), 32'd0);
        @(posedge clk); #1 op_valid = 1'b0;
        v = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) begin v = result; break; end
        end
        m[1] = m[1] + mem_f(32'h50);
        chk(v == m[1], "R12 first command result", v, m[1]);
        mem_lat = 0;
        rd_reg(5, v);
        chk(v == m[5], "R12 busy command ignored", v, m[5]);

        // R11: illegal mode codes.
        for (int code = 10; code < 16; code++) begin
            op_mode = 4'(code); op_dst = 3'd2; op_src = 3'd6; op_idx = 3'd1;
            op_const = 16'h0011; op_valid = 1'b1; nreads = 0;
            @(posedge clk); #1 op_valid = 1'b0;
            @(negedge clk);
            chk(bad_mode && !done && !mem_req, "R11 flag",
                {29'd0, bad_mode, done, mem_req}, 32'd4);
            @(negedge clk);
            chk(!bad_mode && !done && nreads == 0, "R11 pulse end", {31'd0, bad_mode}, 32'd0);
            rd_reg(2, v);
            chk(v == m[2], "R11 dst unchanged", v, m[2]);
            rd_reg(6, r1);
            chk(r1 == m[6], "R11 src unchanged", r1, m[6]);
        end

        // A legal command still works after illegal ones (R3).
        run_op(1, 3, 6, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, v, e);
        chk(v == m[0], "R2 final read", v, m[0]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule